// File: doc/BRIEF.md
# Time-Aware Transmission Gate Scheduler

This block produces an 8-bit gate-open vector, one bit per traffic class, from a programmable list of timed entries that repeats every cycle. Software fills an administrative list through a simple register write port: per-entry masks and intervals, a length, a 64-bit base time, a cycle time and a cycle extension. It then commits the list. The block works out when the committed list may begin. At that instant it takes the list over as the operational schedule and steps through its entries against a free-running 64-bit time input.

A global enable turns scheduling on. While it is off, or before any list has run, every gate is open. Gating is interlocked with a per-queue launch-time mode: neither can be switched on while the other is active. A new list can replace a running one mid-cycle. A new list can also be held back so that the running one is not cut into a short trailing fragment.

Time is compared in absolute units. The mask present after a clock edge is the schedule's value at the `now_i` seen on that edge.

Top module: `tgate_sched`

## Requirements
- R1: After reset, `gate_mask_o` is 0xFF and `gate_en_o`, `launch_en_o`, `run_o` and `err_o` are all zero. `cap_len_o` always reads MAX_LEN.
- R2: While gating is disabled, or while no list has been activated, `gate_mask_o` is 0xFF. Writing 0 to bit 0 at address 0x00 disables gating and drops the running list. Re-enabling leaves the gates open until a committed list reaches its start time.
- R3: Writing 1 to bit 0 at address 0x00 sets `gate_en_o` only if `launch_en_o` is zero. Otherwise the write is ignored.
- R4: A write of bits 7:0 at address 0x01 loads `launch_en_o` only while gating is disabled. Otherwise the write is ignored.
- R5: A write to address 0x07 commits the list. The commit is rejected if the length (address 0x06) is 0 or greater than MAX_LEN, or if the cycle time (address 0x04) is 0. A rejected commit sets `err_o` and leaves the gates unchanged. The next accepted commit clears `err_o`.
- R6: Entry i has its mask at address 0x40+2i (bits 7:0) and its interval at 0x41+2i. The base time has its low word at 0x02 and its high word at 0x03. With a base time in the future, the previous output persists until that time. From then on, entries apply in index order, each for its own interval.
- R7: When the summed intervals reach the cycle time before the list ends, the current entry is cut short. The list restarts at entry 0 at the start of the next cycle, which begins every cycle-time units.
- R8: When the list ends before the cycle time, the last entry's mask is held until the cycle ends.
- R9: A base time of zero starts the list at the value of `now_i` sampled on the commit edge.
- R10: A base time in the past starts the list at the earliest base + n·cycle that is not before the commit-edge time.
- R11: A new list replaces the running one at its start time, even mid-cycle. The old list runs unchanged until then.
- R12: The cycle extension is at address 0x05. When a running cycle ends and the pending start lies after that boundary by less than the pending list's extension, the final mask is held until the pending start. Otherwise the old list restarts at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| now_i | input | 64 | Free-running time count |
| gate_mask_o | output | 8 | Gate-open vector, one bit per class |
| gate_en_o | output | 1 | Global gating enable state |
| launch_en_o | output | 8 | Per-queue launch-time mode enables |
| run_o | output | 1 | An operational list is active |
| entry_idx_o | output | $clog2(MAX_LEN) | Current entry index of the operational list |
| err_o | output | 1 | Last commit was rejected |
| cap_len_o | output | $clog2(MAX_LEN+1) | Maximum list length capability |

## Verification
The bench builds the block with MAX_LEN = 4. This puts the length rejection at a five-entry commit and keeps every list short. The time input advances by one unit per clock and intervals are a few units long, so each entry boundary, cycle wrap, truncation, held tail and extension window falls within a few hundred clocks. A reference model compares the mask in every cycle of each window, including the cycles around the switch from the old list to the new one.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  localparam int NCLS = 8;
  localparam int TW   = 64;
  localparam int DW   = 32;
  localparam int AW   = 8;

  localparam logic [AW-1:0] A_CTRL    = 8'h00;
  localparam logic [AW-1:0] A_LAUNCH  = 8'h01;
  localparam logic [AW-1:0] A_BASE_LO = 8'h02;
  localparam logic [AW-1:0] A_BASE_HI = 8'h03;
  localparam logic [AW-1:0] A_CYCLE   = 8'h04;
  localparam logic [AW-1:0] A_CEXT    = 8'h05;
  localparam logic [AW-1:0] A_LEN     = 8'h06;
  localparam logic [AW-1:0] A_COMMIT  = 8'h07;
  localparam logic [AW-1:0] A_ENT     = 8'h40;

  typedef struct packed {
    logic [NCLS-1:0] gates;
    logic [DW-1:0]   span;
  } slot_t;

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_SEARCH} find_t;

  // end of a segment starting at 'from', clipped to the cycle limit
  function automatic logic [TW-1:0] seg_end(input logic [TW-1:0] from,
                                            input logic [DW-1:0] span,
                                            input logic [TW-1:0] limit);
    logic [TW-1:0] e;
    e = from + TW'(span);
    return (e < limit) ? e : limit;
  endfunction

  // pending start lies just past a boundary, inside the extension window
  function automatic logic stretch_ok(input logic [TW-1:0] bound,
                                      input logic [TW-1:0] pstart,
                                      input logic [DW-1:0] ext);
    return (pstart > bound) && ((pstart - bound) < TW'(ext));
  endfunction
endpackage

// File: rtl/tgs_regs.sv
module tgs_regs import tgs_pkg::*; #(
  parameter int MAX_LEN = 8,
  parameter int IW = 3,
  parameter int LW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  output logic                  gate_en,
  output logic [NCLS-1:0]       lt_en,
  output logic                  err,
  output logic                  commit_ok,
  output logic                  commit_bad,
  output slot_t [MAX_LEN-1:0]   p_slots,
  output logic [LW-1:0]         p_len,
  output logic [TW-1:0]         p_base,
  output logic [DW-1:0]         p_ct,
  output logic [DW-1:0]         p_cte
);
  slot_t [MAX_LEN-1:0] adm_slots;
  logic [15:0]   adm_len;
  logic [TW-1:0] adm_base;
  logic [DW-1:0] adm_ct, adm_cte;

  logic [AW-1:0] ent_off;
  logic          ent_hit, len_ok, commit_req;
  logic [IW-1:0] ent_idx;
  logic [MAX_LEN-1:0] slot_we;

  assign ent_off    = wr_addr - A_ENT;
  assign ent_hit    = wr_en && (wr_addr >= A_ENT) && (ent_off < AW'(2 * MAX_LEN));
  assign ent_idx    = IW'(ent_off >> 1);
  assign commit_req = wr_en && (wr_addr == A_COMMIT);
  assign len_ok     = (adm_len != 16'd0) && (adm_len <= 16'(MAX_LEN)) && (adm_ct != '0);
  assign commit_ok  = commit_req && len_ok;
  assign commit_bad = commit_req && !len_ok;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot_we
    assign slot_we[g] = ent_hit && (ent_idx == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adm_slots <= '0;
      p_slots   <= '0;
    end else begin
      for (int i = 0; i < MAX_LEN; i++) begin
        if (slot_we[i]) begin
          if (ent_off[0]) adm_slots[i].span  <= wr_data;
          else            adm_slots[i].gates <= wr_data[NCLS-1:0];
        end
      end
      if (commit_ok) p_slots <= adm_slots;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adm_len <= '0; adm_base <= '0; adm_ct <= '0; adm_cte <= '0;
      p_len <= '0; p_base <= '0; p_ct <= '0; p_cte <= '0;
      gate_en <= 1'b0; lt_en <= '0; err <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            if (!wr_data[0])       gate_en <= 1'b0;
            else if (lt_en == '0)  gate_en <= 1'b1;
          end
          A_LAUNCH:  if (!gate_en) lt_en <= wr_data[NCLS-1:0];
          A_BASE_LO: adm_base[DW-1:0]  <= wr_data;
          A_BASE_HI: adm_base[TW-1:DW] <= wr_data;
          A_CYCLE:   adm_ct  <= wr_data;
          A_CEXT:    adm_cte <= wr_data;
          A_LEN:     adm_len <= wr_data[15:0];
          default: ;
        endcase
      end
      if (commit_bad) err <= 1'b1;
      if (commit_ok) begin
        err    <= 1'b0;
        p_len  <= LW'(adm_len);
        p_base <= adm_base;
        p_ct   <= adm_ct;
        p_cte  <= adm_cte;
      end
    end
  end
endmodule

// File: rtl/tgs_start.sv
module tgs_start import tgs_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_ok,
  input  logic          take,
  input  logic [TW-1:0] now_i,
  input  logic [TW-1:0] p_base,
  input  logic [DW-1:0] p_ct,
  output logic          pend_valid,
  output logic [TW-1:0] pend_start
);
  find_t         st_q;
  logic [TW-1:0] snap_q, cand_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; snap_q <= '0; cand_q <= '0;
      pend_valid <= 1'b0; pend_start <= '0;
    end else if (commit_ok) begin
      snap_q     <= now_i;
      st_q       <= S_INIT;
      pend_valid <= 1'b0;
    end else begin
      case (st_q)
        S_INIT: begin
          if (p_base == '0) begin
            pend_start <= snap_q;
            pend_valid <= 1'b1;
            st_q       <= S_IDLE;
          end else begin
            cand_q <= p_base;
            st_q   <= S_SEARCH;
          end
        end
        S_SEARCH: begin
          if (cand_q >= snap_q) begin
            pend_start <= cand_q;
            pend_valid <= 1'b1;
            st_q       <= S_IDLE;
          end else begin
            cand_q <= cand_q + TW'(p_ct);
          end
        end
        default: if (take) pend_valid <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tgs_seq.sv
module tgs_seq import tgs_pkg::*; #(
  parameter int MAX_LEN = 8,
  parameter int IW = 3,
  parameter int LW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gate_en,
  input  logic [TW-1:0]       now_i,
  input  logic                pend_valid,
  input  logic [TW-1:0]       pend_start,
  input  slot_t [MAX_LEN-1:0] p_slots,
  input  logic [LW-1:0]       p_len,
  input  logic [DW-1:0]       p_ct,
  input  logic [DW-1:0]       p_cte,
  output logic                take,
  output logic [NCLS-1:0]     mask,
  output logic [IW-1:0]       idx,
  output logic                run,
  output logic                stretch
);
  slot_t [MAX_LEN-1:0] op_q;
  logic [LW-1:0] len_q;
  logic [DW-1:0] ct_q;
  logic [TW-1:0] cend_q, eend_q;
  logic [IW-1:0] idx_q, nxt;
  logic          run_q, str_q, due, at_bound, has_next;

  assign take     = gate_en && pend_valid && (now_i >= pend_start);
  assign due      = run_q && !str_q && (now_i >= eend_q);
  assign at_bound = (eend_q == cend_q);
  assign nxt      = idx_q + 1'b1;
  assign has_next = (32'(idx_q) + 32'd1) < 32'(len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; len_q <= '0; ct_q <= '0; cend_q <= '0; eend_q <= '0;
      idx_q <= '0; run_q <= 1'b0; str_q <= 1'b0;
    end else if (!gate_en) begin
      run_q <= 1'b0;
      str_q <= 1'b0;
    end else if (take) begin
      run_q  <= 1'b1;
      str_q  <= 1'b0;
      op_q   <= p_slots;
      len_q  <= p_len;
      ct_q   <= p_ct;
      idx_q  <= '0;
      cend_q <= pend_start + TW'(p_ct);
      eend_q <= seg_end(pend_start, p_slots[0].span, pend_start + TW'(p_ct));
    end else if (due) begin
      if (at_bound) begin
        if (pend_valid && stretch_ok(cend_q, pend_start, p_cte)) begin
          str_q <= 1'b1;
        end else begin
          idx_q  <= '0;
          cend_q <= cend_q + TW'(ct_q);
          eend_q <= seg_end(cend_q, op_q[0].span, cend_q + TW'(ct_q));
        end
      end else if (has_next) begin
        idx_q  <= nxt;
        eend_q <= seg_end(eend_q, op_q[nxt].span, cend_q);
      end else begin
        eend_q <= cend_q;
      end
    end
  end

  assign mask    = (gate_en && run_q) ? op_q[idx_q].gates : '1;
  assign idx     = idx_q;
  assign run     = run_q;
  assign stretch = str_q;
endmodule

// File: rtl/tgate_sched.sv
module tgate_sched import tgs_pkg::*; #(
  parameter int MAX_LEN = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_en,
  input  logic [7:0]                              wr_addr,
  input  logic [31:0]                             wr_data,
  input  logic [63:0]                             now_i,
  output logic [7:0]                              gate_mask_o,
  output logic                                    gate_en_o,
  output logic [7:0]                              launch_en_o,
  output logic                                    run_o,
  output logic [((MAX_LEN > 1) ? $clog2(MAX_LEN) : 1)-1:0] entry_idx_o,
  output logic                                    err_o,
  output logic [$clog2(MAX_LEN+1)-1:0]            cap_len_o
);
  localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int LW = $clog2(MAX_LEN + 1);

  slot_t [MAX_LEN-1:0] p_slots;
  logic [LW-1:0] p_len;
  logic [TW-1:0] p_base, pend_start;
  logic [DW-1:0] p_ct, p_cte;
  logic          commit_ok, commit_bad, pend_valid, take, stretch;

  tgs_regs #(.MAX_LEN(MAX_LEN), .IW(IW), .LW(LW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .gate_en(gate_en_o), .lt_en(launch_en_o), .err(err_o),
    .commit_ok, .commit_bad, .p_slots, .p_len, .p_base, .p_ct, .p_cte
  );

  tgs_start u_start (
    .clk, .rst_n, .commit_ok, .take, .now_i, .p_base, .p_ct,
    .pend_valid, .pend_start
  );

  tgs_seq #(.MAX_LEN(MAX_LEN), .IW(IW), .LW(LW)) u_seq (
    .clk, .rst_n, .gate_en(gate_en_o), .now_i, .pend_valid, .pend_start,
    .p_slots, .p_len, .p_ct, .p_cte, .take, .mask(gate_mask_o),
    .idx(entry_idx_o), .run(run_o), .stretch
  );

  assign cap_len_o = LW'(MAX_LEN);
endmodule

// File: rtl/tgs_chk.sv
module tgs_chk #(
  parameter int MAX_LEN = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    gate_mask_o,
  input logic [7:0]    launch_en_o,
  input logic          gate_en_o,
  input logic          run_o,
  input logic          err_o,
  input logic          take,
  input logic          commit_bad,
  input logic          stretch,
  input logic [IW-1:0] entry_idx_o
);
  a_r3_no_enable_with_launch: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en_o |-> launch_en_o == 8'h00);

  a_r4_launch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gate_en_o) |-> $stable(launch_en_o));

  a_r5_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    commit_bad |=> err_o);

  a_r2_disable_drops_list: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en_o |=> !run_o);

  a_r11_load_at_entry0: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> run_o && entry_idx_o == '0);

  a_r7_index_order: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && $past(run_o) && !$past(take) && entry_idx_o != $past(entry_idx_o))
      |-> (entry_idx_o == '0 || entry_idx_o == $past(entry_idx_o) + 1'b1));

  a_r12_stretch_holds_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch && $past(stretch) && gate_en_o && $past(gate_en_o)) |-> $stable(gate_mask_o));
endmodule

bind tgate_sched tgs_chk #(.MAX_LEN(MAX_LEN), .IW(IW)) u_chk (.*);

// File: tb/sim_tgate_sched.sv
module sim_tgate_sched;
  localparam int ML = 4;
  localparam int IW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] tnow = 64'd1000;
  logic [7:0]  gate_mask_o, launch_en_o;
  logic        gate_en_o, run_o, err_o;
  logic [IW-1:0] entry_idx_o;
  logic [2:0]  cap_len_o;

  tgate_sched #(.MAX_LEN(ML)) u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .now_i(tnow),
    .gate_mask_o, .gate_en_o, .launch_en_o, .run_o, .entry_idx_o, .err_o, .cap_len_o
  );

  always #4 clk = ~clk;

  typedef struct {
    longint st; longint ct; int n;
    logic [7:0] m [4];
    longint iv [4];
  } plan_t;

  typedef struct { longint t; logic [7:0] m; string tag; } exp_t;

  exp_t   sbq [$];
  int     checks = 0, errors = 0, mchecks = 0, merrors = 0;
  longint wr_now;

  // reference: schedule value at time t
  function automatic logic [7:0] ref_at(plan_t p, longint t);
    longint off, acc;
    if (p.n == 0 || t < p.st) return 8'hFF;
    off = (t - p.st) % p.ct;
    acc = 0;
    for (int i = 0; i < p.n; i++) begin
      if (off < acc + p.iv[i]) return p.m[i];
      acc += p.iv[i];
    end
    return p.m[p.n-1];
  endfunction

  function automatic plan_t mk(longint ct, int n, logic [7:0] m0, m1, m2,
                               longint i0, i1, i2);
    plan_t p;
    p.st = 0; p.ct = ct; p.n = n;
    p.m[0] = m0; p.m[1] = m1; p.m[2] = m2; p.m[3] = 8'h00;
    p.iv[0] = i0; p.iv[1] = i1; p.iv[2] = i2; p.iv[3] = 0;
    return p;
  endfunction

  // monitor: pops expectations as time reaches them, then advances time
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].t < longint'(tnow)) begin
      mchecks++; merrors++;
      $display("FAIL %s: expectation at t=%0d missed (actual n/a expected %02h)",
               sbq[0].tag, sbq[0].t, sbq[0].m);
      void'(sbq.pop_front());
    end
    if (sbq.size() > 0 && sbq[0].t == longint'(tnow)) begin
      mchecks++;
      if (gate_mask_o !== sbq[0].m) begin
        merrors++;
        $display("FAIL %s: mask at t=%0d actual %02h expected %02h",
                 sbq[0].tag, sbq[0].t, gate_mask_o, sbq[0].m);
      end
      void'(sbq.pop_front());
    end
    tnow <= tnow + 64'd1;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    wr_now = longint'(tnow);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_list(input plan_t p, input longint base, input longint ext);
    logic [63:0] b;
    b = 64'(base);
    for (int i = 0; i < p.n; i++) begin
      wr(8'(8'h40 + 2 * i), 32'(p.m[i]));
      wr(8'(8'h41 + 2 * i), 32'(p.iv[i]));
    end
    wr(8'h06, 32'(p.n));
    wr(8'h04, 32'(p.ct));
    wr(8'h05, 32'(ext));
    wr(8'h02, b[31:0]);
    wr(8'h03, b[63:32]);
    wr(8'h07, 32'd0);
  endtask

  // driver: push the expected mask for every time unit of a window
  task automatic push_window(input plan_t oldp, input plan_t newp, input longint from,
                             input longint upto, input longint bd, input bit str,
                             input string tag);
    exp_t e;
    for (longint t = from; t <= upto; t++) begin
      e.t = t; e.tag = tag;
      if (t >= newp.st)           e.m = ref_at(newp, t);
      else if (str && t >= bd)    e.m = ref_at(oldp, bd - 1);
      else                        e.m = ref_at(oldp, t);
      sbq.push_back(e);
    end
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish (actual hung expected done)");
    $display("  CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
    $finish;
  end

  initial begin
    plan_t none, pa, pb, pc, pd, pe;
    longint base, d, bd;
    none = mk(1, 0, 0, 0, 0, 0, 0, 0);
    pa = mk(25, 3, 8'h81, 8'h42, 8'h24, 5, 7, 6);
    pb = mk(24, 3, 8'h11, 8'h22, 8'h33, 10, 10, 10);
    pc = mk(16, 2, 8'h0F, 8'hF0, 8'h00, 8, 8, 0);
    pd = mk(30, 1, 8'h55, 8'h00, 8'h00, 100, 0, 0);
    pe = mk(10, 2, 8'hA0, 8'h0A, 8'h00, 4, 4, 0);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(gate_mask_o == 8'hFF, "R1 mask", gate_mask_o, 8'hFF);
    chk(!gate_en_o && launch_en_o == 0 && !run_o && !err_o, "R1 flags",
        {gate_en_o, launch_en_o, run_o, err_o}, 0);
    chk(cap_len_o == 3'd4, "R1 cap", cap_len_o, 4);

    // R3 / R4 interlock
    wr(8'h01, 32'h05);
    chk(launch_en_o == 8'h05, "R4 load while off", launch_en_o, 5);
    wr(8'h00, 32'h1);
    chk(!gate_en_o, "R3 enable refused", gate_en_o, 0);
    wr(8'h01, 32'h00);
    wr(8'h00, 32'h1);
    chk(gate_en_o, "R3 enable accepted", gate_en_o, 1);
    wr(8'h01, 32'h03);
    chk(launch_en_o == 8'h00, "R4 launch ignored", launch_en_o, 0);
    chk(gate_mask_o == 8'hFF, "R2 no list yet", gate_mask_o, 8'hFF);

    // R5 rejected commits
    wr(8'h06, 32'd5); wr(8'h04, 32'd25); wr(8'h07, 0);
    chk(err_o, "R5 too long", err_o, 1);
    chk(gate_mask_o == 8'hFF && !run_o, "R5 no effect", gate_mask_o, 8'hFF);
    wr(8'h06, 32'd0); wr(8'h07, 0);
    chk(err_o, "R5 zero length", err_o, 1);
    wr(8'h06, 32'd2); wr(8'h04, 32'd0); wr(8'h07, 0);
    chk(err_o && !run_o, "R5 zero cycle", err_o, 1);

    // R6 R8: future base, held tail
    base = longint'(tnow) + 60;
    load_list(pa, base, 0);
    pa.st = base;
    chk(!err_o, "R5 cleared by good commit", err_o, 0);
    push_window(none, pa, wr_now + 2, base + 80, 0, 0, "R6 R8");
    drain();

    // R10 R7 R11: base in the past, truncation, mid-cycle replacement
    base = longint'(tnow) - 52;
    load_list(pb, base, 0);
    d = wr_now - base;
    pb.st = base + ((d + pb.ct - 1) / pb.ct) * pb.ct;
    push_window(pa, pb, wr_now + 2, pb.st + 70, 0, 0, "R10 R7 R11");
    drain();

    // R12 stretch: gap 6 below extension 10
    bd = pb.st + pb.ct * ((longint'(tnow) - pb.st) / pb.ct + 4);
    load_list(pc, bd + 6, 10);
    pc.st = bd + 6;
    push_window(pb, pc, wr_now + 2, pc.st + 40, bd, 1, "R12 stretch");
    drain();

    // R12 no stretch: gap 6 not below extension 3
    bd = pc.st + pc.ct * ((longint'(tnow) - pc.st) / pc.ct + 5);
    load_list(pd, bd + 6, 3);
    pd.st = bd + 6;
    push_window(pc, pd, wr_now + 2, pd.st + 70, bd, 0, "R12 R11 restart");
    drain();

    // R9 R8: base zero anchors to commit time
    load_list(pe, 0, 0);
    pe.st = wr_now;
    push_window(pd, pe, wr_now + 3, wr_now + 45, 0, 0, "R9 R8");
    drain();

    // R2 disable and re-enable
    wr(8'h00, 32'h0);
    chk(gate_mask_o == 8'hFF && !gate_en_o, "R2 disabled open", gate_mask_o, 8'hFF);
    repeat (3) @(negedge clk);
    chk(!run_o, "R2 list dropped", run_o, 0);
    wr(8'h01, 32'h02);
    chk(launch_en_o == 8'h02, "R4 load after disable", launch_en_o, 2);
    wr(8'h01, 32'h00);
    wr(8'h00, 32'h1);
    repeat (6) @(negedge clk);
    chk(gate_mask_o == 8'hFF && !run_o, "R2 re-enable stays open", gate_mask_o, 8'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
    $finish;
  end
endmodule